// File: doc/BRIEF.md
# Smooth Clock Calibration Pulse Masker

This block sits on the slow real-time clock, ahead of the prescaler. Every clock cycle it issues a step code that tells the prescaler how far to advance: 0 when the cycle is masked, 1 for a normal cycle, and 2 when an extra pulse is inserted. Summed over a calibration window, the steps trim the average prescaler rate in steps of one pulse per window. Masked cycles are spread evenly across the window rather than grouped at one end.

Software writes a calibration setting in one strobe. The setting has a window select, a plus bit and a minus count. The setting is staged and takes effect only at the next boundary of the running window. A pending flag stays high from the write until that boundary. The full window is 2^CNT_W cycles, which is 32 s at 32768 Hz with the default CNT_W = 20. The half and quarter windows drop low bits of the minus count, so the correction per unit time stays the same.

Top module: `rtc_smooth_cal`

## Requirements
- R1: After reset, step_o is 1 on every cycle and cal_pend_o is 0. The active setting is full window, plus 0, minus 0.
- R2: Encoding of step_o: 0 means masked, 1 means normal, 2 means inserted; 3 is never driven. With window select 2'b00 the window is 2^CNT_W cycles and exactly minus cycles per window are masked. With minus 0, no cycle is masked.
- R3: With plus set, one step of 2 occurs every 2^INS_LOG2 cycles, at offset 2^(INS_LOG2-1) within each group. An inserted step never lands on a masked cycle and never follows another inserted step.
- R4: Over one full window, the sum of steps equals 2^CNT_W + plus·2^(CNT_W-INS_LOG2) − minus.
- R5: Window select 2'b01 gives a window of 2^(CNT_W-1) cycles with minus>>1 masks per window. Select 2'b10 or 2'b11 gives a window of 2^(CNT_W-2) cycles with minus>>2 masks per window.
- R6: Masked cycles are placed by the bit-reversed index of a slot of 2^(CNT_W-MINUS_W) cycles. With minus = 2^(MINUS_W-1), consecutive masked cycles are exactly 2^(CNT_W-MINUS_W+1) cycles apart.
- R7: A write raises cal_pend_o on the next cycle. The previous setting stays in force, with no change to the step pattern, until cal_pend_o falls.
- R8: At the last cycle of the running window, a pending setting becomes active, cal_pend_o clears and the window counter restarts from 0. The first cycle with cal_pend_o low is slot 0 of the new window, so it is masked whenever the new minus is nonzero.
- R9: A write while a setting is pending replaces the staged setting. Only the last write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Real-time clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_wr_i | input | 1 | Calibration write strobe |
| cal_win_i | input | 2 | Window select: 00 full, 01 half, 1x quarter |
| cal_plus_i | input | 1 | Insert one pulse every 2^INS_LOG2 cycles |
| cal_minus_i | input | MINUS_W | Pulses removed per full window |
| step_o | output | 2 | Prescaler advance for this cycle (0/1/2) |
| cal_pend_o | output | 1 | Staged setting not yet active |

## Verification
step_o is combinational from registers, so it is valid in the same cycle as the counter value it reflects. cal_pend_o is registered and rises one cycle after the write strobe. The bench drives inputs and samples outputs on the falling edge. It checks the pending flag on the first falling edge after the strobe. It polls every cycle until the flag drops, and that sample is taken as cycle 0 of the new window. Sums, mask gaps and insert counts are then taken over exactly one window length from that sample. The bench uses a reduced CNT_W of 12, so the expected totals are computed from the parameters in the requirements.

// File: rtl/rtc_smooth_cal_pkg.sv
package rtc_smooth_cal_pkg;
  typedef enum logic [1:0] {
    WIN_FULL = 2'b00,
    WIN_HALF = 2'b01,
    WIN_QTR  = 2'b10,
    WIN_QTR2 = 2'b11
  } win_sel_e;

  // log2 of window shrink factor
  function automatic logic [1:0] win_shift(input logic [1:0] sel);
    return sel[1] ? 2'd2 : {1'b0, sel[0]};
  endfunction
endpackage

// File: rtl/rtc_smooth_cal_cfg.sv
module rtc_smooth_cal_cfg #(
  parameter int MINUS_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [1:0]         win_i,
  input  logic               plus_i,
  input  logic [MINUS_W-1:0] minus_i,
  input  logic               wrap_i,
  output logic               apply_o,
  output logic               pend_o,
  output logic [1:0]         win_o,
  output logic               plus_o,
  output logic [MINUS_W-1:0] minus_o
);
  logic [1:0]         stg_win_q,  act_win_q;
  logic               stg_plus_q, act_plus_q;
  logic [MINUS_W-1:0] stg_min_q,  act_min_q;
  logic               pend_q;

  assign apply_o = wrap_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_win_q  <= '0;
      stg_plus_q <= 1'b0;
      stg_min_q  <= '0;
      act_win_q  <= '0;
      act_plus_q <= 1'b0;
      act_min_q  <= '0;
      pend_q     <= 1'b0;
    end else begin
      if (wr_i) begin
        stg_win_q  <= win_i;
        stg_plus_q <= plus_i;
        stg_min_q  <= minus_i;
      end
      // old staged value commits even if a new write lands on the boundary
      if (apply_o) begin
        act_win_q  <= stg_win_q;
        act_plus_q <= stg_plus_q;
        act_min_q  <= stg_min_q;
      end
      pend_q <= wr_i | (pend_q & ~wrap_i);
    end
  end

  assign pend_o  = pend_q;
  assign win_o   = act_win_q;
  assign plus_o  = act_plus_q;
  assign minus_o = act_min_q;

  p_pend_after_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pend_o);
  p_active_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_o |=> $stable(act_min_q) && $stable(act_plus_q) && $stable(act_win_q));
  p_pend_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && wrap_i && !wr_i |=> !pend_o);
endmodule

// File: rtl/rtc_smooth_cal_cnt.sv
module rtc_smooth_cal_cnt #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       shift_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] win_mask;

  assign win_mask = {CNT_W{1'b1}} >> shift_i;
  assign wrap_o   = &(cnt_q | ~win_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_smooth_cal_pulse.sv
module rtc_smooth_cal_pulse #(
  parameter int CNT_W    = 20,
  parameter int MINUS_W  = 9,
  parameter int INS_LOG2 = 11
) (
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [1:0]         shift_i,
  input  logic               plus_i,
  input  logic [MINUS_W-1:0] minus_i,
  output logic [1:0]         step_o
);
  localparam int SLOT_LOG2 = CNT_W - MINUS_W;
  localparam logic [INS_LOG2-1:0] INS_MID = INS_LOG2'(1) << (INS_LOG2 - 1);

  logic [MINUS_W-1:0] slot, slot_m, rev, thr;
  logic slot_hit, mask, ins;

  assign slot   = cnt_i[CNT_W-1:SLOT_LOG2];
  assign slot_m = slot & ({MINUS_W{1'b1}} >> shift_i);

  for (genvar i = 0; i < MINUS_W; i++) begin : g_rev
    assign rev[i] = slot_m[MINUS_W-1-i];
  end

  // low minus bits dropped on shorter windows
  assign thr      = minus_i & ({MINUS_W{1'b1}} << shift_i);
  assign slot_hit = (cnt_i[SLOT_LOG2-1:0] == '0);
  assign mask     = slot_hit && (rev < thr);
  // mid-group offset keeps insertions off the slot-aligned mask cycles
  assign ins      = plus_i && (cnt_i[INS_LOG2-1:0] == INS_MID);

  always_comb begin
    if (mask)     step_o = 2'd0;
    else if (ins) step_o = 2'd2;
    else          step_o = 2'd1;
  end
endmodule

// File: rtl/rtc_smooth_cal.sv
module rtc_smooth_cal
  import rtc_smooth_cal_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int MINUS_W  = 9,
  parameter int INS_LOG2 = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cal_wr_i,
  input  logic [1:0]         cal_win_i,
  input  logic               cal_plus_i,
  input  logic [MINUS_W-1:0] cal_minus_i,
  output logic [1:0]         step_o,
  output logic               cal_pend_o
);
  logic [CNT_W-1:0]   cnt;
  logic               wrap, apply;
  logic [1:0]         act_win, shift;
  logic               act_plus;
  logic [MINUS_W-1:0] act_minus;

  assign shift = win_shift(act_win);

  rtc_smooth_cal_cfg #(.MINUS_W(MINUS_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cal_wr_i),
    .win_i   (cal_win_i),
    .plus_i  (cal_plus_i),
    .minus_i (cal_minus_i),
    .wrap_i  (wrap),
    .apply_o (apply),
    .pend_o  (cal_pend_o),
    .win_o   (act_win),
    .plus_o  (act_plus),
    .minus_o (act_minus)
  );

  rtc_smooth_cal_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (shift),
    .restart_i (apply),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  rtc_smooth_cal_pulse #(.CNT_W(CNT_W), .MINUS_W(MINUS_W), .INS_LOG2(INS_LOG2)) u_pulse (
    .cnt_i   (cnt),
    .shift_i (shift),
    .plus_i  (act_plus),
    .minus_i (act_minus),
    .step_o  (step_o)
  );

  p_step_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o != 2'd3);
  p_no_mask_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_minus == '0 |-> step_o != 2'd0);
  p_ins_isolated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o == 2'd2 |=> step_o == 2'd1);
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cal_pend_o) |-> cnt == '0);
endmodule

// File: tb/tb_rtc_smooth_cal.sv
module tb_rtc_smooth_cal;
  localparam int CW = 12;
  localparam int MW = 9;
  localparam int IL = 3;
  localparam int SLOT = 1 << (CW - MW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [1:0]    win = 2'b00;
  logic          plus = 1'b0;
  logic [MW-1:0] minus = '0;
  logic [1:0]    step;
  logic          pend;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  rtc_smooth_cal #(.CNT_W(CW), .MINUS_W(MW), .INS_LOG2(IL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cal_wr_i(wr), .cal_win_i(win),
    .cal_plus_i(plus), .cal_minus_i(minus), .step_o(step), .cal_pend_o(pend)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int win_len(input logic [1:0] s);
    return 1 << (CW - (s[1] ? 2 : int'(s[0])));
  endfunction

  function automatic int exp_sum(input logic [1:0] s, input bit p, input int m);
    int k = s[1] ? 2 : int'(s[0]);
    int l = win_len(s);
    return l + (p ? (l >> IL) : 0) - (m >> k);
  endfunction

  task automatic cfg_write(input logic [1:0] s, input bit p, input int m);
    win = s; plus = p; minus = MW'(m); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_apply(output int zeros);
    zeros = 0;
    while (pend) begin
      if (step == 2'd0) zeros++;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int len, output int sum, output int n0, output int n2,
                         output int first, output bit gap_ok, output bit adj2);
    int last0 = -1;
    int prev = 1;
    sum = 0; n0 = 0; n2 = 0; gap_ok = 1'b1; adj2 = 1'b0; first = int'(step);
    for (int i = 0; i < len; i++) begin
      sum += int'(step);
      if (step == 2'd0) begin
        if (last0 >= 0 && (i - last0) != 2 * SLOT) gap_ok = 1'b0;
        last0 = i;
        n0++;
      end
      if (step == 2'd2) begin
        n2++;
        if (prev == 2) adj2 = 1'b1;
      end
      prev = int'(step);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int sum = 0;
    chk(step == 2'd1, "R1 step", int'(step), 1);
    chk(pend == 1'b0, "R1 pend", int'(pend), 0);
    for (int i = 0; i < 100; i++) begin
      sum += int'(step);
      @(negedge clk);
    end
    chk(sum == 100, "R1 idle sum", sum, 100);
  endtask

  task automatic t_hold_old;
    int z, sum, n0, n2, f;
    bit g, a;
    cfg_write(2'b00, 1'b0, 511);
    chk(pend == 1'b1, "R7 pend rise", int'(pend), 1);
    wait_apply(z);
    chk(z == 0, "R7 old setting kept", z, 0);
    measure(win_len(2'b00), sum, n0, n2, f, g, a);
    chk(f == 0, "R8 slot0 masked at clear", f, 0);
    chk(n0 == 511, "R2 masked count", n0, 511);
    chk(sum == exp_sum(2'b00, 1'b0, 511), "R4 sum minus only", sum, exp_sum(2'b00, 1'b0, 511));
  endtask

  task automatic t_window(input string req, input logic [1:0] s, input bit p, input int m);
    int z, sum, n0, n2, f;
    bit g, a;
    cfg_write(s, p, m);
    chk(pend == 1'b1, "R7 pend rise", int'(pend), 1);
    wait_apply(z);
    measure(win_len(s), sum, n0, n2, f, g, a);
    chk(sum == exp_sum(s, p, m), req, sum, exp_sum(s, p, m));
    if (p) begin
      chk(n2 == (win_len(s) >> IL), "R3 insert count", n2, win_len(s) >> IL);
      chk(!a, "R3 no adjacent inserts", int'(a), 0);
    end
  endtask

  task automatic t_spacing;
    int z, sum, n0, n2, f;
    bit g, a;
    cfg_write(2'b00, 1'b0, 1 << (MW - 1));
    wait_apply(z);
    measure(win_len(2'b00), sum, n0, n2, f, g, a);
    chk(n0 == (1 << (MW - 1)), "R6 mask count", n0, 1 << (MW - 1));
    chk(g, "R6 even spacing", int'(g), 1);
  endtask

  task automatic t_overwrite;
    int z, sum, n0, n2, f;
    bit g, a;
    cfg_write(2'b00, 1'b0, 100);
    cfg_write(2'b00, 1'b1, 1);
    chk(pend == 1'b1, "R9 pend held", int'(pend), 1);
    wait_apply(z);
    measure(win_len(2'b00), sum, n0, n2, f, g, a);
    chk(f == 0, "R8 restart after quarter window", f, 0);
    chk(sum == exp_sum(2'b00, 1'b1, 1), "R9 last write wins", sum, exp_sum(2'b00, 1'b1, 1));
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold_old();
    t_window("R3 plus only", 2'b00, 1'b1, 0);
    t_window("R4 plus and minus", 2'b00, 1'b1, 300);
    t_spacing();
    t_window("R5 half window", 2'b01, 1'b0, 511);
    t_window("R5 quarter window", 2'b10, 1'b1, 7);
    t_window("R5 quarter alt select", 2'b11, 1'b0, 4);
    t_overwrite();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule